// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

This block shifts or rotates a data word by any amount in one pass, with no clock. It is meant for the execute stage of a processor datapath. The amount may come from an instruction's constant field or from a register. Either way, only its low bits reach this block.

The amount is applied through a chain of 2-to-1 multiplexer levels, one level per amount bit. Level k either passes its word through or moves it right by 2^k places. Each level needs a fill for the places it vacates, and the operation chooses that fill: zeros, copies of the sign bit, or the bits that leave the low end. A left shift runs through the same right-moving chain. The word is bit-reversed on the way in, shifted with zero fill, and bit-reversed on the way out.

Top module: `lbs_shifter`

## Requirements
- R1: With `op_sel` = 2'b00 (logical left), `dout` equals `din` moved toward the MSB by `shamt` places, and the low `shamt` bits are 0.
- R2: With `op_sel` = 2'b01 (logical right), `dout` equals `din` moved toward the LSB by `shamt` places, and the top `shamt` bits are 0.
- R3: With `op_sel` = 2'b10 (arithmetic right), `dout` equals `din` moved toward the LSB by `shamt` places, and the top `shamt` bits are copies of `din[WIDTH-1]`.
- R4: With `op_sel` = 2'b11 (rotate right), bit i of `din` appears at bit (i - `shamt`) mod WIDTH of `dout`, and no bit is lost.
- R5: When `shamt` is 0, `dout` equals `din` for all four operations.
- R6: The largest amount, WIDTH-1, gives these results: a logical shift keeps a single bit; an arithmetic right shift gives a word made entirely of sign copies; a rotate equals a rotate left by one.
- R7: `dout` follows `din`, `shamt` and `op_sel` combinationally, in the same cycle, with no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH (32) | Word to shift or rotate |
| shamt | input | log2(WIDTH) (5) | Shift distance, 0 to WIDTH-1 |
| op_sel | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| dout | output | WIDTH (32) | Shifted or rotated word |

## Verification
The hardest case to reach is one where several levels are active at once and each must pick the correct fill. A wrong fill only shows when the bits it brings in differ from the bits already present. A sign fill applied at the wrong level is therefore hidden when the input is zero or all ones. To expose it, the bench sweeps every amount from 0 to 31 for every operation. It uses inputs with a set sign bit, alternating bits and mixed nibbles, so that every combination of active levels meets both fill values. Directed vectors also pin down the ends of the range: amount 0 and amount 31.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [1:0] {
        OP_SHL  = 2'b00,
        OP_SHR  = 2'b01,
        OP_SAR  = 2'b10,
        OP_ROTR = 2'b11
    } shift_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_SIGN = 2'b01,
        FILL_WRAP = 2'b10
    } fill_kind_e;

    function automatic fill_kind_e fill_for(input shift_op_e op);
        unique case (op)
            OP_SHL, OP_SHR: fill_for = FILL_ZERO;
            OP_SAR:         fill_for = FILL_SIGN;
            OP_ROTR:        fill_for = FILL_WRAP;
            default:        fill_for = FILL_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/lbs_reverse.sv
module lbs_reverse #(
    parameter int WIDTH = 32
) (
    input  logic             enable,
    input  logic [WIDTH-1:0] vec_in,
    output logic [WIDTH-1:0] vec_out
);

    logic [WIDTH-1:0] flipped;

    for (genvar i = 0; i < WIDTH; i++) begin : g_flip
        assign flipped[i] = vec_in[WIDTH-1-i];
    end

    assign vec_out = enable ? flipped : vec_in;

endmodule

// File: rtl/lbs_stage.sv
module lbs_stage
    import lbs_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic             step_en,
    input  fill_kind_e       fill,
    input  logic [WIDTH-1:0] vec_in,
    output logic [WIDTH-1:0] vec_out
);

    logic [DIST-1:0]  fill_bits;
    logic [WIDTH-1:0] moved;

    // A sign fill reads the MSB of this level's input. Earlier sign-fill
    // levels only ever copy the sign bit into the top, so that MSB is still
    // the sign of the original word.
    always_comb begin
        unique case (fill)
            FILL_SIGN: fill_bits = {DIST{vec_in[WIDTH-1]}};
            FILL_WRAP: fill_bits = vec_in[DIST-1:0];
            default:   fill_bits = '0;
        endcase
    end

    assign moved   = {fill_bits, vec_in[WIDTH-1:DIST]};
    assign vec_out = step_en ? moved : vec_in;

endmodule

// File: rtl/lbs_shifter.sv
module lbs_shifter
    import lbs_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] shamt,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] dout
);

    localparam int LEVELS = AMT_W;

    shift_op_e        op;
    fill_kind_e       fill;
    logic             is_left;
    logic [WIDTH-1:0] chain [0:LEVELS];

    assign op      = shift_op_e'(op_sel);
    assign fill    = fill_for(op);
    assign is_left = (op == OP_SHL);

    lbs_reverse #(.WIDTH(WIDTH)) u_rev_in (
        .enable  (is_left),
        .vec_in  (din),
        .vec_out (chain[0])
    );

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        lbs_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
            .step_en (shamt[k]),
            .fill    (fill),
            .vec_in  (chain[k]),
            .vec_out (chain[k+1])
        );
    end

    lbs_reverse #(.WIDTH(WIDTH)) u_rev_out (
        .enable  (is_left),
        .vec_in  (chain[LEVELS]),
        .vec_out (dout)
    );

    // Port-level checks. They are skipped while any input is unknown.
    always_comb begin
        if (!$isunknown({din, shamt, op_sel})) begin
            if (shamt == '0)
                AST_ZERO_AMT_IDENTITY: assert (dout == din);                      // R5
            if (op_sel == 2'b00 && shamt != '0)
                AST_SHL_LSB_CLEAR: assert (dout[0] == 1'b0);                       // R1
            if (op_sel == 2'b01 && shamt != '0)
                AST_SHR_MSB_CLEAR: assert (dout[WIDTH-1] == 1'b0);                 // R2
            if (op_sel == 2'b10)
                AST_SAR_SIGN_KEPT: assert (dout[WIDTH-1] == din[WIDTH-1]);         // R3
            if (op_sel == 2'b11)
                AST_ROTR_ONES_KEPT: assert ($countones(dout) == $countones(din));  // R4
        end
    end

endmodule

// File: tb/lbs_shifter_tb.sv
module lbs_shifter_tb;

    localparam int W = 32;
    localparam int N_VEC = 14;
    localparam int N_PAT = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din;
    logic [4:0]   shamt;
    logic [1:0]   op_sel;
    logic [W-1:0] dout;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    lbs_shifter #(.WIDTH(W)) u_dut (
        .din    (din),
        .shamt  (shamt),
        .op_sel (op_sel),
        .dout   (dout)
    );

    // Each entry is {din, shamt, op_sel, expected}.
    localparam logic [70:0] VEC [N_VEC] = '{
        {32'h8000_0001, 5'd1,  2'b00, 32'h0000_0002},
        {32'h8000_0001, 5'd1,  2'b01, 32'h4000_0000},
        {32'h8000_0001, 5'd1,  2'b10, 32'hC000_0000},
        {32'h8000_0001, 5'd1,  2'b11, 32'hC000_0000},
        {32'h1234_5678, 5'd4,  2'b00, 32'h2345_6780},
        {32'h1234_5678, 5'd4,  2'b01, 32'h0123_4567},
        {32'h1234_5678, 5'd4,  2'b11, 32'h8123_4567},
        {32'hF000_0000, 5'd31, 2'b10, 32'hFFFF_FFFF},
        {32'h7FFF_FFFF, 5'd31, 2'b10, 32'h0000_0000},
        {32'hFFFF_FFFF, 5'd31, 2'b01, 32'h0000_0001},
        {32'hFFFF_FFFF, 5'd31, 2'b00, 32'h8000_0000},
        {32'hA5A5_A5A5, 5'd0,  2'b11, 32'hA5A5_A5A5},
        {32'h0000_0001, 5'd31, 2'b11, 32'h0000_0002},
        {32'hAAAA_AAAA, 5'd16, 2'b10, 32'hFFFF_AAAA}
    };

    localparam logic [W-1:0] PAT [N_PAT] = '{
        32'hFFFF_FFFF, 32'h5555_5555, 32'hAAAA_AAAA,
        32'h8000_0000, 32'h8000_0001, 32'h1234_5678
    };

    function automatic string req_of(input logic [1:0] op, input logic [4:0] a);
        if (a == 5'd0) return "R5";
        if (a == 5'd31) return "R6";
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic [4:0] a,
                                           input logic [1:0] op);
        logic [2*W-1:0] dbl;
        dbl = {d, d} >> a;
        case (op)
            2'b00:   return d << a;
            2'b01:   return d >> a;
            2'b10:   return $unsigned($signed(d) >>> a);
            default: return dbl[W-1:0];
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: din=%h shamt=%0d op=%b actual=%h expected=%h",
                     req, din, shamt, op_sel, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] d, input logic [4:0] a, input logic [1:0] op);
        @(posedge clk);
        din    = d;
        shamt  = a;
        op_sel = op;
        @(negedge clk);
    endtask

    initial begin
        din = '0; shamt = '0; op_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5", dout, '0);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i][70:39], VEC[i][38:34], VEC[i][33:32]);
            check(req_of(VEC[i][33:32], VEC[i][38:34]), dout, VEC[i][31:0]);
        end

        for (int p = 0; p < N_PAT; p++) begin
            for (int o = 0; o < 4; o++) begin
                for (int a = 0; a < W; a++) begin
                    apply(PAT[p], 5'(a), 2'(o));
                    check(req_of(2'(o), 5'(a)), dout, model(PAT[p], 5'(a), 2'(o)));
                end
            end
        end

        // R7: changing only the operation changes the result within the same cycle.
        @(posedge clk);
        din = 32'h8000_00F0; shamt = 5'd4; op_sel = 2'b01;
        #1 check("R7", dout, 32'h0800_000F);
        op_sel = 2'b10;
        #1 check("R7", dout, 32'hF800_000F);
        op_sel = 2'b11;
        #1 check("R7", dout, 32'h0800_000F);
        @(negedge clk);

        done = 1'b1;
    end

    initial begin : watchdog
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule